// File: doc/BRIEF.md
# Latching Relay Programming Sequencer

This block drives the serial programming of eight magnetically latching relays that select input coupling and attenuation for two input channels, four relays per channel. The relays hang off a 16-bit shift chain built from two 8-bit registers. For every relay the sequencer shifts in a one-hot word, pulses the register latch, and then fires the relay strobe that sets the one coil whose bit is high. After the last relay it reuses the same chain to load one auxiliary word that carries the mode bits.

A run always rewrites all eight relays, in order, and then the auxiliary word. It is never a partial update. A run starts when the effective coupling or attenuation request differs from the state last applied, or when a reload request arrives. An overload flag on a channel pulls that channel's 50 Ω request back to the 1 MΩ DC position, and that counts as a change. Requests and changes that arrive during a run are not lost: a new full run follows, built from the settings present when it starts.

Top module: `relay_seq_ctrl`

## Requirements
- R1: After reset, ser_data, ser_clk, reg_latch, relay_strobe, busy and load_ack are all low, and they stay low until a run is triggered.
- R2: A pulse on load_req while idle starts one run of nine words. busy rises in the same cycle as the first shift cycle and falls in the cycle after the latch pulse of the auxiliary word.
- R3: Each word is sent MSB first, two clocks per bit. ser_data changes only together with a falling ser_clk and is held while ser_clk is high. After the 16th bit, reg_latch is high for exactly one clock, with ser_clk low.
- R4: Relay words go out in relay order 0 to 7. Relays 0 to 3 use channel A (bits [1:0] of each setting input) and relays 4 to 7 use channel B (bits [3:2]). The word for relay r has only bit 2r+p set. The value of p depends on the relay's position k within its channel: for k=0, p is 1 when the coupling code is 3 (50 Ω); for k=1, p is 1 when the coupling code is 1 (AC); for k=2, p is atten[0]; for k=3, p is atten[1].
- R5: relay_strobe rises in the clock right after each relay word's latch pulse and stays high for STROBE_LEN clocks. STROBE_LEN idle clocks follow before the next word's first bit is presented. ser_clk and relay_strobe are never high together.
- R6: After relay 7's gap, the auxiliary word is sent with bits [15:8] = aux_cfg[7:0], bits [1:0] = aux_cfg[9:8] and all other bits zero. No strobe follows it.
- R7: While idle, a change in the effective coupling or attenuation starts a full run without load_req. A change of aux_cfg alone starts nothing.
- R8: While ovld[c] is high, a coupling code of 3 on channel c is applied as code 0 (DC, 1 MΩ). Asserting ovld[c] while channel c requests code 3 reruns the full sequence.
- R9: A load_req or a settings change during a run causes one more full run after the current one ends. That run uses the settings present when it starts.
- R10: load_ack is high for one clock in the cycle after each clock in which load_req is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_atten | input | 2*NUM_CH | Requested attenuation code, 2 bits per channel |
| cfg_coup | input | 2*NUM_CH | Requested coupling code, 2 bits per channel (0 DC, 1 AC, 3 50 Ω) |
| ovld | input | NUM_CH | Per-channel overload indication |
| aux_cfg | input | AUX_W | Auxiliary mode bits loaded after the relays |
| load_req | input | 1 | Force-reload request |
| load_ack | output | 1 | Acknowledge of a load request |
| ser_data | output | 1 | Serial data to the shift chain |
| ser_clk | output | 1 | Shift clock to the shift chain |
| reg_latch | output | 1 | Shift-register output latch pulse |
| relay_strobe | output | 1 | Relay set strobe |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with STROBE_LEN set to 4 and the default two channels. This keeps one nine-word run short enough that pending reruns, overload forcing and about twenty random settings fit easily in the run. With the short strobe, the bench measures every strobe width and every settle gap exactly, and the one-hot map is checked for all eight relays under every combination of coupling and attenuation codes it draws. The same bench also covers the back-to-back cases: a reload or a settings change that lands in the middle of a run.

// File: rtl/relay_seq_pkg.sv
package relay_seq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_STROBE,
        ST_GAP,
        ST_AUX
    } seq_state_e;

    // Coupling code that selects the 50 ohm termination
    localparam logic [1:0] COUP_TERM = 2'b11;
    // Coupling code that selects AC coupling
    localparam logic [1:0] COUP_AC   = 2'b01;
    // Coupling code used when overload forces the high-impedance path
    localparam logic [1:0] COUP_HIZ  = 2'b00;

endpackage

// File: rtl/relay_word_map.sv
module relay_word_map #(
    parameter int NUM_CH        = 2,
    parameter int RELAYS_PER_CH = 4,
    localparam int NUM_RELAYS   = NUM_CH * RELAYS_PER_CH,
    localparam int WORD_W       = 2 * NUM_RELAYS,
    localparam int IDX_W        = $clog2(NUM_RELAYS)
) (
    input  logic [2*NUM_CH-1:0] atten,
    input  logic [2*NUM_CH-1:0] coup,
    input  logic [IDX_W-1:0]    idx,
    output logic [WORD_W-1:0]   word
);
    import relay_seq_pkg::*;

    // One position bit per relay: which of its two coils gets energised
    logic [NUM_RELAYS-1:0] pos_vec;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [1:0] c_code;
        logic [1:0] a_code;
        assign c_code = coup[2*ch +: 2];
        assign a_code = atten[2*ch +: 2];
        for (genvar k = 0; k < RELAYS_PER_CH; k++) begin : g_rly
            if (k == 0) begin : g_term
                assign pos_vec[ch*RELAYS_PER_CH + k] = (c_code == COUP_TERM);
            end else if (k == 1) begin : g_acdc
                assign pos_vec[ch*RELAYS_PER_CH + k] = (c_code == COUP_AC);
            end else if (k == 2) begin : g_att_lo
                assign pos_vec[ch*RELAYS_PER_CH + k] = a_code[0];
            end else begin : g_att_hi
                assign pos_vec[ch*RELAYS_PER_CH + k] = a_code[1];
            end
        end
    end

    // Contact index is 2*relay + position
    assign word = WORD_W'(1) << {idx, pos_vec[idx]};

endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sdata,
    output logic              sclk,
    output logic              latch
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              active;
        logic              latch;
        logic              sclk;
        logic              sdata;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        if (q.active) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
            end else if (q.cnt == CNT_W'(WORD_W - 1)) begin
                d.active = 1'b0;
                d.sclk   = 1'b0;
                d.sdata  = 1'b0;
                d.latch  = 1'b1;
            end else begin
                d.sclk  = 1'b0;
                d.cnt   = q.cnt + 1'b1;
                d.sdata = q.sh[WORD_W-2];
                d.sh    = q.sh << 1;
            end
        end else if (q.latch) begin
            d.latch = 1'b0;
        end else if (start) begin
            d.active = 1'b1;
            d.sh     = word;
            d.sdata  = word[WORD_W-1];
            d.sclk   = 1'b0;
            d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdata = q.sdata;
    assign sclk  = q.sclk;
    assign latch = q.latch;

endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int LEN   = 16,
    localparam int CNT_W = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.cnt = CNT_W'(LEN - 1);
        end else if (q.run) begin
            if (q.cnt == '0) d.run = 1'b0;
            else             d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // High during the last clock of the programmed window
    assign fire = q.run && (q.cnt == '0);

endmodule

// File: rtl/relay_seq_ctrl.sv
module relay_seq_ctrl #(
    parameter int NUM_CH        = 2,
    parameter int RELAYS_PER_CH = 4,
    parameter int STROBE_LEN    = 16,
    parameter int AUX_W         = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NUM_CH-1:0] cfg_atten,
    input  logic [2*NUM_CH-1:0] cfg_coup,
    input  logic [NUM_CH-1:0]   ovld,
    input  logic [AUX_W-1:0]    aux_cfg,
    input  logic                load_req,
    output logic                load_ack,
    output logic                ser_data,
    output logic                ser_clk,
    output logic                reg_latch,
    output logic                relay_strobe,
    output logic                busy
);
    import relay_seq_pkg::*;

    localparam int NUM_RELAYS = NUM_CH * RELAYS_PER_CH;
    localparam int WORD_W     = 2 * NUM_RELAYS;
    localparam int IDX_W      = $clog2(NUM_RELAYS);
    localparam int AT_W       = 2 * NUM_CH;
    localparam int CFG_W      = 2 * AT_W;
    localparam int AUX_MAIN   = AUX_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RELAYS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  ridx;
        logic              pend;
        logic [CFG_W-1:0]  applied;
        logic [WORD_W-1:0] auxw;
        logic              strobe;
        logic              busy;
        logic              ack;
    } ctl_t;

    ctl_t q, d;

    // Effective request after overload forcing
    logic [AT_W-1:0]   eff_coup;
    logic [CFG_W-1:0]  eff_cfg;
    logic [WORD_W-1:0] aux_word;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_force
        assign eff_coup[2*ch +: 2] =
            (ovld[ch] && (cfg_coup[2*ch +: 2] == COUP_TERM)) ? COUP_HIZ : cfg_coup[2*ch +: 2];
    end

    assign eff_cfg = {eff_coup, cfg_atten};

    always_comb begin
        aux_word = '0;
        aux_word[WORD_W-1 -: AUX_MAIN] = aux_cfg[AUX_MAIN-1:0];
        aux_word[1:0]                  = aux_cfg[AUX_W-1:AUX_MAIN];
    end

    // Word selection for the engine
    logic [IDX_W-1:0]  map_idx;
    logic [WORD_W-1:0] map_word;
    logic [WORD_W-1:0] eng_word;
    logic              eng_start;
    logic              eng_latch;
    logic              tmr_start;
    logic              tmr_fire;

    assign map_idx  = (q.st == ST_LOAD) ? '0 : q.ridx + 1'b1;
    assign eng_word = (q.st == ST_GAP && q.ridx == LAST_IDX) ? q.auxw : map_word;

    relay_word_map #(
        .NUM_CH        (NUM_CH),
        .RELAYS_PER_CH (RELAYS_PER_CH)
    ) u_map (
        .atten (q.applied[AT_W-1:0]),
        .coup  (q.applied[CFG_W-1:AT_W]),
        .idx   (map_idx),
        .word  (map_word)
    );

    ser_shift_engine #(
        .WORD_W (WORD_W)
    ) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .word  (eng_word),
        .sdata (ser_data),
        .sclk  (ser_clk),
        .latch (eng_latch)
    );

    step_timer #(
        .LEN (STROBE_LEN)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .fire  (tmr_fire)
    );

    always_comb begin
        d         = q;
        d.ack     = load_req;
        eng_start = 1'b0;
        tmr_start = 1'b0;

        if (load_req && q.st != ST_IDLE) d.pend = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (load_req || q.pend || (eff_cfg != q.applied)) begin
                    d.st      = ST_LOAD;
                    d.applied = eff_cfg;
                    d.auxw    = aux_word;
                    d.pend    = 1'b0;
                end
            end
            ST_LOAD: begin
                eng_start = 1'b1;
                d.ridx    = '0;
                d.busy    = 1'b1;
                d.st      = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (eng_latch) begin
                    d.st      = ST_STROBE;
                    d.strobe  = 1'b1;
                    tmr_start = 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_fire) begin
                    d.strobe  = 1'b0;
                    d.st      = ST_GAP;
                    tmr_start = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_fire) begin
                    eng_start = 1'b1;
                    if (q.ridx == LAST_IDX) begin
                        d.st = ST_AUX;
                    end else begin
                        d.ridx = q.ridx + 1'b1;
                        d.st   = ST_SHIFT;
                    end
                end
            end
            ST_AUX: begin
                if (eng_latch) begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_latch    = eng_latch;
    assign relay_strobe = q.strobe;
    assign busy         = q.busy;
    assign load_ack     = q.ack;

endmodule

// File: rtl/relay_seq_chk.sv
module relay_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_data,
    input logic ser_clk,
    input logic reg_latch,
    input logic relay_strobe,
    input logic busy
);
    // R5
    clk_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_clk && relay_strobe));

    // R3
    latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_latch |=> !reg_latch);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_data));

    // R5
    strobe_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_strobe) |-> $past(reg_latch));

    // R5
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        relay_strobe |-> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(reg_latch));

endmodule

bind relay_seq_ctrl relay_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_data     (ser_data),
    .ser_clk      (ser_clk),
    .reg_latch    (reg_latch),
    .relay_strobe (relay_strobe),
    .busy         (busy)
);

// File: tb/sim_relay_seq_ctrl.sv
module sim_relay_seq_ctrl;
    localparam int SL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] at = '0;
    logic [3:0] cp = '0;
    logic [1:0] ov = '0;
    logic [9:0] ax = '0;
    logic       load_req = 1'b0;
    logic       load_ack, ser_data, ser_clk, reg_latch, relay_strobe, busy;

    always #4 clk = ~clk;

    relay_seq_ctrl #(.STROBE_LEN(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_atten(at), .cfg_coup(cp), .ovld(ov),
        .aux_cfg(ax), .load_req(load_req), .load_ack(load_ack), .ser_data(ser_data),
        .ser_clk(ser_clk), .reg_latch(reg_latch), .relay_strobe(relay_strobe), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] eff_c(input logic [1:0] c, input logic o);
        return (o && c == 2'd3) ? 2'd0 : c;
    endfunction

    function automatic logic [7:0] eff_all(input logic [3:0] a, input logic [3:0] c, input logic [1:0] o);
        return {eff_c(c[3:2], o[1]), eff_c(c[1:0], o[0]), a};
    endfunction

    function automatic logic [15:0] exp_word(input logic [3:0] a, input logic [3:0] c,
                                             input logic [1:0] o, input logic [9:0] x, input int idx);
        int ch, k;
        logic [1:0] cc, aa;
        logic p;
        if (idx == 8) return {x[7:0], 6'b0, x[9:8]};
        ch = idx / 4;
        k  = idx % 4;
        cc = eff_c(c[2*ch +: 2], o[ch]);
        aa = a[2*ch +: 2];
        case (k)
            0:       p = (cc == 2'd3);
            1:       p = (cc == 2'd1);
            2:       p = aa[0];
            default: p = aa[1];
        endcase
        return 16'h1 << (2*idx + int'(p));
    endfunction

    // Monitor of the serial chain
    logic [15:0] log_w [0:63];
    int          log_n = 0;
    logic [15:0] shv = '0;
    int          bitc = 0;
    logic        pclk = 0, plat = 0, pstr = 0, pbusy = 0;
    int          slen = 0, glen = 0;
    bit          in_gap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !pclk) begin
                shv = {shv[14:0], ser_data};
                bitc++;
            end
            if (reg_latch) begin
                chk(bitc == 16 && !ser_clk, "R3 sixteen bits then latch with clock low", bitc, 16);
                if (log_n < 64) log_w[log_n] = shv;
                log_n++;
                bitc = 0;
            end
            if (relay_strobe) begin
                if (!pstr) chk(plat, "R5 strobe right after latch", plat, 1);
                slen++;
            end else if (pstr) begin
                chk(slen == SL, "R5 strobe width", slen, SL);
                slen = 0;
                in_gap = 1;
                glen = 0;
            end
            // gap of SL idle clocks plus one data set-up clock before the first rising shift clock
            if (in_gap && !relay_strobe) begin
                if (ser_clk) begin
                    chk(glen == SL + 1, "R5 settle gap", glen, SL + 1);
                    in_gap = 0;
                end else glen++;
            end
            if (busy && !pbusy) chk(!ser_clk && bitc == 0, "R2 busy rises at first shift", ser_clk, 0);
            if (!busy && pbusy) chk(plat, "R2 busy falls after aux latch", plat, 1);
            if (!busy && (ser_clk || relay_strobe || reg_latch))
                chk(0, "R1 outputs quiet while idle", {ser_clk, relay_strobe, reg_latch}, 0);
            pclk  = ser_clk;
            plat  = reg_latch;
            pstr  = relay_strobe;
            pbusy = busy;
        end
    end

    task automatic clear_log();
        log_n = 0;
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] c, input logic [1:0] o,
                         input logic [9:0] x, input bit ld);
        @(negedge clk);
        at = a; cp = c; ov = o; ax = x; load_req = ld;
        @(negedge clk);
        if (ld) chk(load_ack, "R10 ack follows request", load_ack, 1);
        load_req = 1'b0;
        @(negedge clk);
        if (ld) chk(!load_ack, "R10 ack lasts one clock", load_ack, 0);
    endtask

    task automatic settle();
        int quiet = 0;
        int n = 0;
        while (quiet < 12 && n < 8000) begin
            @(negedge clk);
            n++;
            if (busy) quiet = 0;
            else quiet++;
        end
        chk(quiet >= 12, "R2 run completes", quiet, 12);
    endtask

    task automatic chk_run(input int base, input logic [3:0] a, input logic [3:0] c,
                           input logic [1:0] o, input logic [9:0] x);
        for (int i = 0; i < 9; i++) begin
            if (i < 8) chk(log_w[base+i] == exp_word(a, c, o, x, i), "R4 relay word",
                           log_w[base+i], exp_word(a, c, o, x, i));
            else       chk(log_w[base+i] == exp_word(a, c, o, x, i), "R6 aux word",
                           log_w[base+i], exp_word(a, c, o, x, i));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] prev_eff;
        int unsigned seed;
        seed = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ser_data, ser_clk, reg_latch, relay_strobe, busy, load_ack} == '0,
            "R1 reset outputs", {ser_data, ser_clk, reg_latch, relay_strobe, busy, load_ack}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(log_n == 0 && !busy, "R1 idle after reset", log_n, 0);

        // R2 R4 R6 directed load
        clear_log();
        apply(4'b0110, 4'b1101, 2'b00, 10'h2A5, 1);
        settle();
        chk(log_n == 9, "R2 nine words", log_n, 9);
        chk_run(0, 4'b0110, 4'b1101, 2'b00, 10'h2A5);

        // R7 aux-only change starts nothing
        clear_log();
        apply(4'b0110, 4'b1101, 2'b00, 10'h15A, 0);
        repeat (60) @(negedge clk);
        chk(log_n == 0 && !busy, "R7 aux change ignored", log_n, 0);

        // R7 coupling change without request
        clear_log();
        apply(4'b0110, 4'b1111, 2'b00, 10'h15A, 0);
        settle();
        chk(log_n == 9, "R7 change reruns", log_n, 9);
        chk_run(0, 4'b0110, 4'b1111, 2'b00, 10'h15A);

        // R8 overload on channel A forces high impedance
        clear_log();
        apply(4'b0110, 4'b1111, 2'b01, 10'h15A, 0);
        settle();
        chk(log_n == 9, "R8 overload reruns", log_n, 9);
        chk(log_w[0] == 16'h0001, "R8 channel A forced off 50 ohm", log_w[0], 16'h0001);
        chk(log_w[4] == 16'h0200, "R8 channel B keeps 50 ohm", log_w[4], 16'h0200);
        chk_run(0, 4'b0110, 4'b1111, 2'b01, 10'h15A);

        // R9 request during a run, second run takes new aux
        clear_log();
        apply(4'b1001, 4'b0001, 2'b00, 10'h0F0, 1);
        repeat (60) @(negedge clk);
        apply(4'b1001, 4'b0001, 2'b00, 10'h30F, 1);
        settle();
        chk(log_n == 18, "R9 pending request reruns", log_n, 18);
        chk_run(0, 4'b1001, 4'b0001, 2'b00, 10'h0F0);
        chk_run(9, 4'b1001, 4'b0001, 2'b00, 10'h30F);

        // R9 change during a run
        clear_log();
        apply(4'b1001, 4'b0001, 2'b00, 10'h30F, 1);
        repeat (100) @(negedge clk);
        apply(4'b0011, 4'b0001, 2'b00, 10'h30F, 0);
        settle();
        chk(log_n == 18, "R9 change during run reruns", log_n, 18);
        chk_run(0, 4'b1001, 4'b0001, 2'b00, 10'h30F);
        chk_run(9, 4'b0011, 4'b0001, 2'b00, 10'h30F);

        // Random settings
        prev_eff = eff_all(4'b0011, 4'b0001, 2'b00);
        for (int it = 0; it < 24; it++) begin
            logic [3:0] ra, rc;
            logic [1:0] ro;
            logic [9:0] rx;
            bit         rl;
            int         nexp;
            ra = 4'($urandom); rc = 4'($urandom); ro = 2'($urandom);
            rx = 10'($urandom); rl = 1'($urandom);
            nexp = (rl || eff_all(ra, rc, ro) != prev_eff) ? 9 : 0;
            clear_log();
            apply(ra, rc, ro, rx, rl);
            settle();
            chk(log_n == nexp, "R7 random run count", log_n, nexp);
            if (nexp == 9 && log_n == 9) chk_run(0, ra, rc, ro, rx);
            prev_eff = eff_all(ra, rc, ro);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule